// File: doc/BRIEF.md
# Automatic Straight-Through / Crossover Pair Selector

This block decides whether an Ethernet PHY drives its pairs straight through (MDI) or swapped (MDIX). In automatic mode it hunts: the selection flips, waits a pseudo-random number of millisecond ticks, then flips again. It keeps doing this until the receive side reports energy on the wire. While that signal is present the choice is frozen and copied to a status bit. If the signal goes away, hunting resumes with a fresh interval.

Two controls can stop the hunt. A configuration bit forces a mode chosen by a second configuration bit. An active-high disable pin forces MDI. The configuration bit wins over the pin. The waiting time comes from a 16-bit maximal-length LFSR. The LFSR steps once for every flip, so successive intervals differ and two link partners running the same logic fall out of step.

Top module: `mdix_ctrl`

## Requirements
- R1: After reset `mdix_sel` is 0 (MDI), `mdix_stat` is 0, the LFSR holds `LFSR_SEED` and the interval counter is at zero.
- R2: Automatic mode is active only when `pin_auto_dis` is 0 and `cfg_auto_off` is 0. With no signal detected in that mode, `mdix_sel` alternates between 0 and 1 without end.
- R3: Each hunting interval lasts `MIN_MS + (L mod SPAN_MS)` counted ticks, where L is the current LFSR value. After every flip the LFSR advances once as a right-shifting Galois register: it shifts right by one, and if the bit shifted out was 1 it is XORed with 16'hB400. With the defaults every interval is 200 to 420 ticks.
- R4: Only clock edges with `ms_tick` high count toward an interval. Cycles without a tick never cause a flip.
- R5: While `sig_detect` is high in automatic mode, `mdix_sel` does not change and the interval counter stays at zero.
- R6: At each edge where `sig_detect` is high in automatic mode, `mdix_stat` takes the current selection. While hunting, `mdix_stat` keeps its last value.
- R7: When `sig_detect` falls in automatic mode, hunting restarts from the held selection, and the first flip comes after a full interval computed from the current LFSR value.
- R8: While `cfg_auto_off` is 1, `mdix_sel` equals `cfg_force_x` (0 = MDI, 1 = MDIX) whatever the pin says, and `mdix_stat` shows that value one edge later.
- R9: While `pin_auto_dis` is 1 and `cfg_auto_off` is 0, `mdix_sel` is 0, and `mdix_stat` is 0 one edge later.
- R10: While automatic mode is off, the hunting selection returns to MDI and the counter to zero, and the LFSR keeps its state. On re-entry, the first flip (to MDIX) comes after the interval of the retained LFSR value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sig_detect | input | 1 | Received signal present on the media |
| pin_auto_dis | input | 1 | Pin level; 1 disables automatic mode and forces MDI |
| cfg_auto_off | input | 1 | Configuration bit; 1 disables automatic mode in favour of `cfg_force_x` |
| cfg_force_x | input | 1 | Configuration mode used when `cfg_auto_off` is 1 (1 = MDIX) |
| mdix_sel | output | 1 | Pair-swap select, 1 = crossover |
| mdix_stat | output | 1 | Status: selection last locked or forced |

## Verification
The bench builds the block with `MIN_MS = 20` and `SPAN_MS = 11` and leaves the seed and taps at their defaults. This makes each interval 20 to 30 ticks, so several successive LFSR-driven intervals, a lock, a loss and a re-entry fit in a few hundred cycles. Most scenarios pulse `ms_tick` every cycle. One scenario spaces the ticks out, so the count is checked against ticks and not against cycles.

// File: rtl/mdix_ctrl.sv
module mdix_ctrl #(
  parameter int          MIN_MS    = 200,
  parameter int          SPAN_MS   = 221,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic sig_detect,
  input  logic pin_auto_dis,
  input  logic cfg_auto_off,
  input  logic cfg_force_x,
  output logic mdix_sel,
  output logic mdix_stat
);
  localparam int CNT_W = $clog2(MIN_MS + SPAN_MS + 1);

  logic [15:0]      lfsr, lfsr_next;
  logic [CNT_W-1:0] cnt, limit;
  logic             hunt_x, auto_on, ovr_sel, wrap;

  assign auto_on   = !pin_auto_dis && !cfg_auto_off;
  assign ovr_sel   = cfg_auto_off ? cfg_force_x : 1'b0;
  assign mdix_sel  = auto_on ? hunt_x : ovr_sel;
  assign lfsr_next = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? LFSR_TAPS : 16'h0000);
  assign limit     = CNT_W'(MIN_MS) + CNT_W'(lfsr % 16'(SPAN_MS));
  assign wrap      = (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= LFSR_SEED;
      cnt       <= '0;
      hunt_x    <= 1'b0;
      mdix_stat <= 1'b0;
    end else if (!auto_on) begin
      cnt       <= '0;
      hunt_x    <= 1'b0;
      mdix_stat <= ovr_sel;
    end else if (sig_detect) begin
      cnt       <= '0;
      mdix_stat <= hunt_x;
    end else if (ms_tick) begin
      if (wrap) begin
        cnt    <= '0;
        hunt_x <= ~hunt_x;
        lfsr   <= lfsr_next;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/mdix_ctrl_chk.sv
module mdix_ctrl_chk #(
  parameter int MIN_MS  = 200,
  parameter int SPAN_MS = 221
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic sig_detect,
  input logic pin_auto_dis,
  input logic cfg_auto_off,
  input logic cfg_force_x,
  input logic mdix_sel,
  input logic mdix_stat
);
  logic        auto_on, prev_sel, prev_auto, toggled;
  logic [31:0] ticks;

  assign auto_on = !pin_auto_dis && !cfg_auto_off;
  assign toggled = auto_on && prev_auto && (mdix_sel != prev_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel  <= 1'b0;
      prev_auto <= 1'b0;
      ticks     <= '0;
    end else begin
      prev_sel  <= mdix_sel;
      prev_auto <= auto_on;
      if (!auto_on || sig_detect) ticks <= '0;
      else ticks <= (toggled ? 32'd0 : ticks) + (ms_tick ? 32'd1 : 32'd0);
    end
  end

  assert_toggle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    toggled |-> (ticks >= 32'(MIN_MS)) && (ticks <= 32'(MIN_MS + SPAN_MS - 1)));

  assert_no_tick_no_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && prev_auto && !$past(ms_tick)) |-> (mdix_sel == prev_sel));

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && sig_detect) ##1 auto_on |-> $stable(mdix_sel));

  assert_stat_on_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && sig_detect) |=> (mdix_stat == $past(mdix_sel)));

  assert_forced_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto_off |=> (mdix_stat == $past(cfg_force_x)));

  assert_pin_mdi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_auto_dis && !cfg_auto_off) |-> !mdix_sel);
endmodule

bind mdix_ctrl mdix_ctrl_chk #(.MIN_MS(MIN_MS), .SPAN_MS(SPAN_MS)) chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sig_detect(sig_detect),
  .pin_auto_dis(pin_auto_dis), .cfg_auto_off(cfg_auto_off),
  .cfg_force_x(cfg_force_x), .mdix_sel(mdix_sel), .mdix_stat(mdix_stat)
);

// File: tb/mdix_ctrl_test.sv
module mdix_ctrl_test;
  localparam int          MIN  = 20;
  localparam int          SPAN = 11;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 0, sig_detect = 0, pin_auto_dis = 0, cfg_auto_off = 0, cfg_force_x = 0;
  logic mdix_sel, mdix_stat;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m;

  always #10 clk = ~clk;

  mdix_ctrl #(.MIN_MS(MIN), .SPAN_MS(SPAN)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sig_detect(sig_detect),
    .pin_auto_dis(pin_auto_dis), .cfg_auto_off(cfg_auto_off),
    .cfg_force_x(cfg_force_x), .mdix_sel(mdix_sel), .mdix_stat(mdix_stat)
  );

  function automatic logic [15:0] nxt(input logic [15:0] l);
    return {1'b0, l[15:1]} ^ (l[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic int lim(input logic [15:0] l);
    return MIN + int'(l) % SPAN;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit check);
    @(negedge clk);
    rst_n = 0; ms_tick = 0; sig_detect = 0; pin_auto_dis = 0;
    cfg_auto_off = 0; cfg_force_x = 0;
    step(3);
    rst_n = 1;
    m = SEED;
    if (check) begin
      step(2);
      chk("R1 sel after reset", mdix_sel, 0);
      chk("R1 stat after reset", mdix_stat, 0);
    end
  endtask

  task automatic one_flip(input string req, input int from);
    int l = lim(m);
    ms_tick = 1;
    step(l - 1);
    chk({req, " before flip"}, mdix_sel, from);
    step(1);
    chk({req, " at flip"}, mdix_sel, 1 - from);
    m = nxt(m);
  endtask

  task automatic test_hunt;
    do_reset(1);
    for (int i = 0; i < 4; i++) one_flip("R2 R3 hunt interval", i % 2);
    chk("R6 stat holds while hunting", mdix_stat, 0);
  endtask

  task automatic test_tick_gaps;
    int l;
    do_reset(0);
    l = lim(m);
    for (int i = 0; i < l - 1; i++) begin
      ms_tick = 1; step(1);
      ms_tick = 0; step(2);
    end
    step(10);
    chk("R4 no flip before last tick", mdix_sel, 0);
    ms_tick = 1; step(1);
    ms_tick = 0;
    chk("R4 flip on last tick", mdix_sel, 1);
  endtask

  task automatic test_lock_and_loss;
    do_reset(0);
    one_flip("R2 first flip", 0);
    sig_detect = 1;
    step(1);
    chk("R6 stat on lock", mdix_stat, 1);
    step(3 * (MIN + SPAN));
    chk("R5 sel held while locked", mdix_sel, 1);
    chk("R5 stat held while locked", mdix_stat, 1);
    sig_detect = 0;
    one_flip("R7 full interval after loss", 1);
    chk("R6 stat kept after loss", mdix_stat, 1);
  endtask

  task automatic test_forced;
    do_reset(0);
    ms_tick = 1;
    cfg_auto_off = 1; cfg_force_x = 1;
    #1 chk("R8 forced MDIX sel", mdix_sel, 1);
    step(1);
    chk("R8 forced MDIX stat", mdix_stat, 1);
    pin_auto_dis = 1;
    step(3 * (MIN + SPAN));
    chk("R8 register beats pin", mdix_sel, 1);
    cfg_force_x = 0;
    #1 chk("R8 forced MDI sel", mdix_sel, 0);
    step(1);
    chk("R8 forced MDI stat", mdix_stat, 0);
  endtask

  task automatic test_pin_and_resume;
    do_reset(0);
    one_flip("R2 flip before pin", 0);
    sig_detect = 1; step(1); sig_detect = 0;
    chk("R6 stat locked MDIX", mdix_stat, 1);
    pin_auto_dis = 1;
    #1 chk("R9 pin forces MDI sel", mdix_sel, 0);
    step(1);
    chk("R9 pin forces MDI stat", mdix_stat, 0);
    step(3 * (MIN + SPAN));
    chk("R9 stays MDI under pin", mdix_sel, 0);
    pin_auto_dis = 0;
    #1 chk("R10 resume at MDI", mdix_sel, 0);
    one_flip("R10 retained LFSR interval", 0);
  endtask

  initial begin
    test_hunt();
    test_tick_gaps();
    test_lock_and_loss();
    test_forced();
    test_pin_and_resume();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule